// File: doc/BRIEF.md
# Handshake-Paced Byte Transfer Engine

This block sits on the controller side of a byte link to a host processor. The host paces every transfer with two active-low level signals. The first, `tip_n`, marks a transfer as in progress. The second, `tack_n`, is a byte acknowledge that the host flips once per byte. The engine answers on a single active-low request line, `req_n`. An 8-bit shift register carries the data. The engine does not clock that register bit by bit: it moves one whole byte each time the host changes the level of either handshake line.

The direction input chooses which way bytes travel. When it is high, the host is sending, and the engine appends each presented shift-register byte to an outbound buffer. When the host ends the transfer, the engine issues a one-cycle packet strobe that carries the byte count and the buffer contents. When the direction input is low, the engine hands out a reply. The reply is first loaded in one cycle through the reply port, and each handshake change then places the next reply byte in the shift register. The request line tells the host that reply bytes are waiting, and it follows the acknowledge line while no transfer is running. A sticky flag records every byte moved and every end of transfer. It feeds the interrupt logic.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset `req_n` is 1, `sr_flag` is 0, `pkt_valid` is 0 and `sr_out` is 0.
- R2: While `tip_n` is 0 and `host_to_ctrl` is 1, every clock in which the pair {`tip_n`,`tack_n`} differs from its value in the previous clock stores `sr_in` at the next outbound position, starting at position 0 (byte i at `pkt_data[8i+7:8i]`). This includes the clock in which `tip_n` falls. Once DEPTH bytes are held, further bytes are dropped. A clock with no change stores nothing. Each stored byte sets `sr_flag`.
- R3: While `tip_n` is 1 in both the current and the previous clock, each change of `tack_n` inverts `req_n` one clock later.
- R4: While `tip_n` is 0 and `host_to_ctrl` is 0, every handshake change, as defined in R2, drives the next unread reply byte onto `sr_out` one clock later and sets `sr_flag`. When the last reply byte is driven, `req_n` goes to 1 in the same clock.
- R5: A rise of `tip_n` ends the transfer and sets `sr_flag` one clock later, even when no byte moved.
- R6: At the end of a transfer in which at least one outbound byte was stored, `pkt_valid` is 1 for exactly one clock, with `pkt_len` equal to the number of bytes stored. The next transfer stores from position 0 again. An end with no stored byte gives no strobe.
- R7: At the end of a transfer, if unread reply bytes remain, `req_n` goes to 0.
- R8: A `rpl_load` pulse copies `rpl_data` and `rpl_len` (clamped to DEPTH) into the reply buffer and restarts reading at byte 0. If the pulse comes while `tip_n` is 1 and the length is nonzero, `req_n` goes to 0 one clock later.
- R9: `flag_clr` clears `sr_flag` one clock later. If a set event happens in the same clock, the set wins (default option).
- R10: While `host_to_ctrl` is 0 and no unread reply byte remains, handshake changes leave `sr_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| tack_n | input | 1 | Host byte acknowledge, active low, level changes pace bytes |
| host_to_ctrl | input | 1 | Direction: 1 = host sends, 0 = engine replies |
| sr_in | input | DW | Shift-register byte presented by the host |
| sr_out | output | DW | Reply byte placed in the shift register for the host |
| req_n | output | 1 | Transfer request to the host, active low |
| sr_flag | output | 1 | Sticky shift-register event flag |
| flag_clr | input | 1 | Clears sr_flag |
| pkt_valid | output | 1 | One-clock strobe: an outbound packet is complete |
| pkt_len | output | CW | Outbound byte count, valid with pkt_valid |
| pkt_data | output | DEPTH*DW | Outbound buffer, byte i in bits [DW*i +: DW] |
| rpl_load | input | 1 | Loads a new reply |
| rpl_len | input | CW | Reply length in bytes |
| rpl_data | input | DEPTH*DW | Reply bytes, byte i in bits [DW*i +: DW] |

## Verification
Outbound transfers are run with idle clocks between handshake changes, so a count of three proves that held levels store nothing, and with seventeen acknowledge flips, which shows the drop at the depth limit. Reply transfers are run with a full drain in one transfer, with a drain split over two transfers, which separates the end-of-transfer request (R7) from the last-byte release (R4), and with surplus flips after the last byte. An empty transfer in reply direction separates the unconditional end flag from the packet strobe. A clear that coincides with an end of transfer exposes the flag priority.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

   // Handshake events decoded from one clock of the host lines.
   typedef struct packed {
      logic active;      // transfer in progress this clock
      logic changed;     // pair differs from last clock while active
      logic idle_flip;   // ack moved while idle in both clocks
      logic ending;      // in-progress line released this clock
   } hs_event_t;

endpackage

// File: rtl/hs_xfer_edge.sv
module hs_xfer_edge
   import hs_xfer_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tip_n,
   input  logic      tack_n,
   output hs_event_t ev
);

   logic tip_q;
   logic tack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tip_q  <= 1'b1;
         tack_q <= 1'b1;
      end else begin
         tip_q  <= tip_n;
         tack_q <= tack_n;
      end
   end

   always_comb begin
      ev.active    = !tip_n;
      ev.changed   = !tip_n && ({tip_n, tack_n} != {tip_q, tack_q});
      ev.idle_flip = tip_n && tip_q && (tack_n != tack_q);
      ev.ending    = tip_n && !tip_q;
   end

endmodule

// File: rtl/hs_xfer_collect.sv
module hs_xfer_collect #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [DW-1:0]       sr_in,
   input  logic                close,
   output logic                stored,
   output logic [CW-1:0]       cnt,
   output logic                pkt_valid,
   output logic [CW-1:0]       pkt_len,
   output logic [DEPTH*DW-1:0] pkt_data
);

   logic accept;
   assign accept = capture && (cnt < CW'(DEPTH));
   assign stored = accept;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (accept && (cnt == CW'(i)))
            slot_q <= sr_in;
      end
      assign pkt_data[i*DW +: DW] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         pkt_valid <= close && (cnt != '0);
         if (close) begin
            pkt_len <= cnt;
            cnt     <= '0;
         end else if (accept) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hs_xfer_feed.sv
module hs_xfer_feed #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [CW-1:0]       load_len,
   input  logic [DEPTH*DW-1:0] load_data,
   input  logic                advance,
   output logic [DW-1:0]       rd_byte,
   output logic                moved,
   output logic                last,
   output logic                pending
);

   logic [DW-1:0] rbuf [DEPTH];
   logic [CW-1:0] len_q;
   logic [CW-1:0] idx_q;
   logic [CW-1:0] eff_len;
   logic [CW-1:0] idx_nx;

   assign eff_len = (load_len > CW'(DEPTH)) ? CW'(DEPTH) : load_len;
   assign pending = idx_q < len_q;
   assign moved   = advance && !load && pending;
   assign idx_nx  = idx_q + 1'b1;
   assign last    = moved && (idx_nx == len_q);

   for (genvar i = 0; i < DEPTH; i++) begin : g_rslot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbuf[i] <= '0;
         else if (load)
            rbuf[i] <= load_data[i*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         idx_q   <= '0;
         rd_byte <= '0;
      end else if (load) begin
         len_q <= eff_len;
         idx_q <= '0;
      end else if (moved) begin
         rd_byte <= rbuf[idx_q[IW-1:0]];
         idx_q   <= idx_nx;
      end
   end

endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
   import hs_xfer_pkg::*;
#(
   parameter int DW            = 8,
   parameter int DEPTH         = 16,
   parameter bit FLAG_SET_WINS = 1'b1,
   localparam int CW           = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tip_n,
   input  logic                tack_n,
   input  logic                host_to_ctrl,
   input  logic [DW-1:0]       sr_in,
   output logic [DW-1:0]       sr_out,
   output logic                req_n,
   output logic                sr_flag,
   input  logic                flag_clr,
   output logic                pkt_valid,
   output logic [CW-1:0]       pkt_len,
   output logic [DEPTH*DW-1:0] pkt_data,
   input  logic                rpl_load,
   input  logic [CW-1:0]       rpl_len,
   input  logic [DEPTH*DW-1:0] rpl_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("hs_xfer_engine: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("hs_xfer_engine: DW must be at least 1");
   end

   hs_event_t     ev;
   logic          out_stored;
   logic [CW-1:0] out_cnt;
   logic          in_moved;
   logic          in_last;
   logic          in_pending;
   logic          flag_set;

   hs_xfer_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tip_n  (tip_n),
      .tack_n (tack_n),
      .ev     (ev)
   );

   hs_xfer_collect #(.DW(DW), .DEPTH(DEPTH)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (ev.changed && host_to_ctrl),
      .sr_in     (sr_in),
      .close     (ev.ending),
      .stored    (out_stored),
      .cnt       (out_cnt),
      .pkt_valid (pkt_valid),
      .pkt_len   (pkt_len),
      .pkt_data  (pkt_data)
   );

   hs_xfer_feed #(.DW(DW), .DEPTH(DEPTH)) u_feed (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rpl_load),
      .load_len  (rpl_len),
      .load_data (rpl_data),
      .advance   (ev.changed && !host_to_ctrl),
      .rd_byte   (sr_out),
      .moved     (in_moved),
      .last      (in_last),
      .pending   (in_pending)
   );

   // Request line: new reply, last byte out, idle follow, end-of-transfer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_n <= 1'b1;
      else if (rpl_load && !ev.active && (rpl_len != '0))
         req_n <= 1'b0;
      else if (in_last)
         req_n <= 1'b1;
      else if (ev.idle_flip)
         req_n <= !req_n;
      else if (ev.ending && in_pending)
         req_n <= 1'b0;
   end

   assign flag_set = ev.ending || out_stored || in_moved;

   if (FLAG_SET_WINS) begin : g_flag_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sr_flag <= 1'b0;
         else if (flag_set) sr_flag <= 1'b1;
         else if (flag_clr) sr_flag <= 1'b0;
      end
   end else begin : g_flag_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sr_flag <= 1'b0;
         else if (flag_clr) sr_flag <= 1'b0;
         else if (flag_set) sr_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/hs_xfer_checker.sv
module hs_xfer_checker #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tip_n,
   input logic          tack_n,
   input logic          req_n,
   input logic          sr_flag,
   input logic          flag_clr,
   input logic          rpl_load,
   input logic          pkt_valid,
   input logic [CW-1:0] pkt_len,
   input logic [CW-1:0] out_cnt
);

   logic tip_q;
   logic tack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tip_q  <= 1'b1;
         tack_q <= 1'b1;
      end else begin
         tip_q  <= tip_n;
         tack_q <= tack_n;
      end
   end

   // R2: the outbound count never passes the buffer depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= CW'(DEPTH));

   // R3: idle acknowledge flip inverts the request line
   a_r3_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (tip_n && tip_q && (tack_n != tack_q) && !rpl_load) |=> (req_n != $past(req_n)));

   // R5: release of the in-progress line raises the flag
   a_r5_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tip_n && !tip_q && !flag_clr) |=> sr_flag);

   // R6: packet strobe lasts one clock
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> !pkt_valid);

   // R6: a strobed packet carries a length within 1..DEPTH
   a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> ((pkt_len != '0) && (pkt_len <= CW'(DEPTH))));

endmodule

bind hs_xfer_engine hs_xfer_checker #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tip_n     (tip_n),
   .tack_n    (tack_n),
   .req_n     (req_n),
   .sr_flag   (sr_flag),
   .flag_clr  (flag_clr),
   .rpl_load  (rpl_load),
   .pkt_valid (pkt_valid),
   .pkt_len   (pkt_len),
   .out_cnt   (out_cnt)
);

// File: tb/sim_hs_xfer_engine.sv
`timescale 1ns/1ps
module sim_hs_xfer_engine;

   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH + 1);

   logic                clk = 1'b0;
   logic                rst_n;
   logic                tip_n, tack_n, host_to_ctrl, flag_clr, rpl_load;
   logic [DW-1:0]       sr_in, sr_out;
   logic                req_n, sr_flag, pkt_valid;
   logic [CW-1:0]       pkt_len, rpl_len;
   logic [DEPTH*DW-1:0] pkt_data, rpl_data;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   hs_xfer_engine #(.DW(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .tack_n(tack_n),
      .host_to_ctrl(host_to_ctrl), .sr_in(sr_in), .sr_out(sr_out),
      .req_n(req_n), .sr_flag(sr_flag), .flag_clr(flag_clr),
      .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
      .rpl_load(rpl_load), .rpl_len(rpl_len), .rpl_data(rpl_data)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_reply(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int n);
      rpl_data = '0;
      rpl_data[7:0]   = b0;
      rpl_data[15:8]  = b1;
      rpl_data[23:16] = b2;
      rpl_len  = CW'(n);
      rpl_load = 1'b1;
      tick();
      rpl_load = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      tick();
      flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "req_n", req_n, 1);
      chk("R1", "sr_flag", sr_flag, 0);
      chk("R1", "pkt_valid", pkt_valid, 0);
      chk("R1", "sr_out", sr_out, 0);
   endtask

   task automatic t_outbound();
      host_to_ctrl = 1'b1;
      sr_in = 8'hA1; tip_n = 1'b0; tick();
      chk("R2", "flag after byte", sr_flag, 1);
      tick();
      sr_in = 8'hB2; tack_n = 1'b0; tick();
      sr_in = 8'hC3; tack_n = 1'b1; tick();
      tick();
      tip_n = 1'b1; tick();
      chk("R6", "strobe", pkt_valid, 1);
      chk("R6", "len", pkt_len, 3);
      chk("R2", "byte0", pkt_data[7:0], 8'hA1);
      chk("R2", "byte1", pkt_data[15:8], 8'hB2);
      chk("R2", "byte2", pkt_data[23:16], 8'hC3);
      tick();
      chk("R6", "strobe width", pkt_valid, 0);
      chk("R3", "req idle", req_n, 1);
      clear_flag();
      chk("R9", "flag cleared", sr_flag, 0);
   endtask

   task automatic t_overflow();
      host_to_ctrl = 1'b1;
      sr_in = 8'h00; tip_n = 1'b0; tick();
      for (int k = 1; k <= 17; k++) begin
         sr_in = 8'(k); tack_n = ~tack_n; tick();
      end
      tip_n = 1'b1; tick();
      chk("R2", "capped len", pkt_len, DEPTH);
      chk("R6", "strobe", pkt_valid, 1);
      chk("R2", "first byte", pkt_data[7:0], 8'h00);
      chk("R2", "last kept", pkt_data[DEPTH*DW-1 -: DW], 8'(DEPTH-1));
      clear_flag();
   endtask

   task automatic t_idle_follow();
      tack_n = ~tack_n; tick();
      chk("R3", "first flip", req_n, 0);
      tack_n = ~tack_n; tick();
      chk("R3", "second flip", req_n, 1);
      tick();
      chk("R3", "held", req_n, 1);
   endtask

   task automatic t_empty();
      host_to_ctrl = 1'b0;
      tip_n = 1'b0; tick();
      tack_n = ~tack_n; tick();
      chk("R10", "no reply data", sr_out, 0);
      tip_n = 1'b1; tick();
      chk("R5", "end flag", sr_flag, 1);
      chk("R6", "no strobe", pkt_valid, 0);
      clear_flag();
   endtask

   task automatic t_inbound();
      host_to_ctrl = 1'b0;
      load_reply(8'h11, 8'h22, 8'h33, 3);
      chk("R8", "req on load", req_n, 0);
      tip_n = 1'b0; tick();
      chk("R4", "byte0", sr_out, 8'h11);
      chk("R4", "flag", sr_flag, 1);
      tack_n = ~tack_n; tick();
      chk("R4", "byte1", sr_out, 8'h22);
      chk("R4", "req held", req_n, 0);
      tack_n = ~tack_n; tick();
      chk("R4", "byte2", sr_out, 8'h33);
      chk("R4", "req released", req_n, 1);
      tack_n = ~tack_n; tick();
      chk("R10", "surplus flip", sr_out, 8'h33);
      tip_n = 1'b1; tick();
      chk("R5", "end flag", sr_flag, 1);
      chk("R7", "nothing left", req_n, 1);
      clear_flag();
   endtask

   task automatic t_split();
      host_to_ctrl = 1'b0;
      load_reply(8'h44, 8'h55, 8'h66, 3);
      chk("R8", "req on load", req_n, 0);
      tack_n = ~tack_n; tick();
      chk("R3", "idle flip high", req_n, 1);
      tip_n = 1'b0; tick();
      chk("R4", "first", sr_out, 8'h44);
      tip_n = 1'b1; tick();
      chk("R7", "rerequest", req_n, 0);
      tip_n = 1'b0; tick();
      chk("R8", "continues", sr_out, 8'h55);
      tack_n = ~tack_n; tick();
      chk("R4", "last", sr_out, 8'h66);
      chk("R4", "release", req_n, 1);
      tip_n = 1'b1; tick();
      clear_flag();
   endtask

   task automatic t_set_wins();
      host_to_ctrl = 1'b0;
      tip_n = 1'b0; tick();
      tip_n = 1'b1; flag_clr = 1'b1; tick();
      chk("R9", "set wins", sr_flag, 1);
      tick();
      chk("R9", "clear after", sr_flag, 0);
      flag_clr = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; tip_n = 1'b1; tack_n = 1'b1; host_to_ctrl = 1'b0;
      sr_in = '0; flag_clr = 1'b0; rpl_load = 1'b0; rpl_len = '0; rpl_data = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_outbound();
      t_overflow();
      t_idle_follow();
      t_empty();
      t_inbound();
      t_split();
      t_set_wins();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule